// File: doc/BRIEF.md
# Masked Local-Bus Interrupt Encoder

This block gathers sixteen level-sensitive device interrupt lines into one combined request for the processor. Each line is brought into the clock domain through a synchronizer and then captured in a status bit that follows its level. A software-visible enable mask decides which status bits count as pending. The combined request is raised while at least one pending bit exists.

Software reaches the block through a small 16-bit register port. One word returns a vector code that names the lowest-numbered pending line, so a handler can jump straight to it without scanning a bitmap. A second word holds the enable mask, which can be read back and written a whole word or a single byte at a time. The mask leaves reset with only line 4 enabled.

Top module: `lbi_encoder`

## Requirements
- R1: A status bit follows the level of its input line. A change on the line reaches the status bit three clock edges after the line is sampled: two synchronizer flops, then the status flop.
- R2: `irq_o` is high exactly when (status AND mask) is non-zero. It is registered, so it trails the status and mask registers by one clock edge.
- R3: A read of word offset 0x0 returns (n+1)<<2, where n is the lowest-numbered line that is both set in status and enabled in the mask. It returns 0 when no line is pending.
- R4: Byte offset 0x2 holds the enable mask and can be read and written. Read data appears on `bus_rdata_o` after the clock edge that samples `bus_rd_i`, and it is held until the next read.
- R5: A mask write changes `irq_o` on the clock edge after the write edge.
- R6: After reset the mask reads 0x0010, all status bits are zero, `irq_o` is low, and the source code reads 0.
- R7: A write with `bus_be_i`=2'b01 updates only mask bits 7:0. A write with 2'b10 updates only bits 15:8. The other byte keeps its value.
- R8: Writes to offset 0x0 have no effect on the mask or on `irq_o`.
- R9: Reads of any word offset other than 0x0 and 0x2 return 0.
- R10: A line whose mask bit is 0 affects neither `irq_o` nor the source code, even while its input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| irq_lines_i | input | 16 | Device interrupt lines, active high, asynchronous |
| bus_addr_i | input | 4 | Byte address. Bit 0 is ignored and bytes are chosen by `bus_be_i` |
| bus_rd_i | input | 1 | Read strobe for one cycle |
| bus_wr_i | input | 1 | Write strobe for one cycle |
| bus_be_i | input | 2 | Byte enables. Bit 0 selects data bits 7:0 and bit 1 selects bits 15:8 |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The encoder is driven with line patterns that have one line set, several lines set at once (which separates a lowest-index encoder from a highest-index one), the end lines 0 and 15, and lines outside the enabled set (which separates masked from raw status). Mask writes are checked cycle by cycle on `irq_o`, which tells a registered output one edge late apart from a combinational or two-edge path. Byte writes to each half use data that differs in every nibble, so a lost merge or a swapped lane shows in the read-back. Writes to the source word and reads of unused words confirm that neither reaches the mask or returns stale data.

// File: rtl/lbi_pkg.sv
package lbi_pkg;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned BYTES    = DATA_W / 8;
  // word indices (byte address >> 1)
  localparam int unsigned WORD_SRC  = 0;
  localparam int unsigned WORD_MASK = 1;
endpackage

// File: rtl/lbi_sync.sv
module lbi_sync #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = async_i;
      end else begin : g_rest
        assign stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/lbi_prio_enc.sv
module lbi_prio_enc #(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned CODE_W    = 16
) (
  input  logic [NUM_LINES-1:0] pend_i,
  output logic [CODE_W-1:0]    code_o
);
  // lowest index wins: scan from the top so lower indices overwrite
  always_comb begin
    code_o = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (pend_i[i]) code_o = CODE_W'((i + 1) << 2);
    end
  end
endmodule

// File: rtl/lbi_mask_reg.sv
module lbi_mask_reg
  import lbi_pkg::*;
#(
  parameter logic [DATA_W-1:0] RESET_VAL = 16'h0010
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [BYTES-1:0]   be_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  mask_o
);
  logic [DATA_W-1:0] mask_q, mask_d;

  always_comb begin
    mask_d = mask_q;
    for (int b = 0; b < BYTES; b++) begin
      if (be_i[b]) mask_d[b*8 +: 8] = wdata_i[b*8 +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= RESET_VAL;
    else if (wr_en_i) mask_q <= mask_d;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/lbi_encoder.sv
module lbi_encoder
  import lbi_pkg::*;
#(
  parameter int unsigned       NUM_LINES   = 16,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter int unsigned       ADDR_W      = 4,
  parameter logic [DATA_W-1:0] MASK_RESET  = 16'h0010
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_lines_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic                 bus_rd_i,
  input  logic                 bus_wr_i,
  input  logic [BYTES-1:0]     bus_be_i,
  input  logic [DATA_W-1:0]    bus_wdata_i,
  output logic [DATA_W-1:0]    bus_rdata_o,
  output logic                 irq_o
);
  localparam int unsigned WORD_W = ADDR_W - 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n = rst_pipe_q[1];

  // synchronized lines and status capture
  logic [NUM_LINES-1:0] sync_lines;
  logic [NUM_LINES-1:0] status_q;
  logic [DATA_W-1:0]    mask_q;
  logic [NUM_LINES-1:0] pend;
  logic [DATA_W-1:0]    src_code;

  lbi_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .async_i(irq_lines_i),
    .sync_o (sync_lines)
  );

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= sync_lines;
  end

  // register decode
  logic [WORD_W-1:0] word_idx;
  logic              sel_src, sel_mask, mask_wr;
  assign word_idx = bus_addr_i[ADDR_W-1:1];
  assign sel_src  = (word_idx == WORD_W'(WORD_SRC));
  assign sel_mask = (word_idx == WORD_W'(WORD_MASK));
  assign mask_wr  = bus_wr_i && sel_mask;

  lbi_mask_reg #(.RESET_VAL(MASK_RESET)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .wr_en_i(mask_wr),
    .be_i   (bus_be_i),
    .wdata_i(bus_wdata_i),
    .mask_o (mask_q)
  );

  assign pend = status_q & mask_q[NUM_LINES-1:0];

  lbi_prio_enc #(.NUM_LINES(NUM_LINES), .CODE_W(DATA_W)) u_enc (
    .pend_i(pend),
    .code_o(src_code)
  );

  // combined request and read data: next-state then register
  logic              irq_d, irq_q;
  logic [DATA_W-1:0] rdata_d, rdata_q;

  always_comb begin
    irq_d   = |pend;
    rdata_d = '0;
    if (sel_src)       rdata_d = src_code;
    else if (sel_mask) rdata_d = mask_q;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (bus_rd_i) rdata_q <= rdata_d;
  end

  assign irq_o       = irq_q;
  assign bus_rdata_o = rdata_q;
endmodule

// File: rtl/lbi_encoder_chk.sv
module lbi_encoder_chk #(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned ADDR_W    = 4
) (
  input logic                 clk_i,
  input logic                 rst_n,
  input logic [NUM_LINES-1:0] sync_lines,
  input logic [NUM_LINES-1:0] status_q,
  input logic [15:0]          mask_q,
  input logic [ADDR_W-1:0]    bus_addr_i,
  input logic                 bus_rd_i,
  input logic                 bus_wr_i,
  input logic [1:0]           bus_be_i,
  input logic [15:0]          bus_rdata_o,
  input logic                 irq_o
);
  logic [ADDR_W-2:0] widx;
  assign widx = bus_addr_i[ADDR_W-1:1];

  assert_status_follow_R1: assert property (@(posedge clk_i) disable iff (!rst_n)
    status_q == $past(sync_lines));

  assert_irq_pending_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_o == $past(|(status_q & mask_q[NUM_LINES-1:0])));

  assert_low_byte_kept_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bus_wr_i && widx == 1 && bus_be_i == 2'b10) |=> $stable(mask_q[7:0]));

  assert_high_byte_kept_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bus_wr_i && widx == 1 && bus_be_i == 2'b01) |=> $stable(mask_q[15:8]));

  assert_src_write_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (widx != 1 || !bus_wr_i) |=> $stable(mask_q));

  assert_unknown_read_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bus_rd_i && widx > 1) |=> bus_rdata_o == 16'h0000);
endmodule

bind lbi_encoder lbi_encoder_chk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_n      (rst_n),
  .sync_lines (sync_lines),
  .status_q   (status_q),
  .mask_q     (mask_q),
  .bus_addr_i (bus_addr_i),
  .bus_rd_i   (bus_rd_i),
  .bus_wr_i   (bus_wr_i),
  .bus_be_i   (bus_be_i),
  .bus_rdata_o(bus_rdata_o),
  .irq_o      (irq_o)
);

// File: tb/sim_lbi_encoder.sv
module sim_lbi_encoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] lines;
  logic [3:0]  addr;
  logic        rd, wr;
  logic [1:0]  be;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        irq;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  lbi_encoder u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_lines_i(lines),
    .bus_addr_i(addr), .bus_rd_i(rd), .bus_wr_i(wr), .bus_be_i(be),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [1:0] b, input logic [15:0] d);
    @(negedge clk);
    addr = a; be = b; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; be = 2'b00;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic set_lines(input logic [15:0] v);
    @(negedge clk);
    lines = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    check("R6 irq after reset", {15'd0, irq}, 16'h0);
    bus_read(4'h2, d); check("R6 mask reset", d, 16'h0010);
    bus_read(4'h0, d); check("R6 source reset", d, 16'h0000);
  endtask

  task automatic t_single_line;
    logic [15:0] d;
    @(negedge clk); lines = 16'h0010;
    repeat (3) @(negedge clk);
    check("R1 status not yet through", {15'd0, irq}, 16'h0);
    @(negedge clk);
    check("R1 R2 irq four edges after line", {15'd0, irq}, 16'h1);
    bus_read(4'h0, d); check("R3 source line 4", d, 16'h0014);
  endtask

  task automatic t_masked_lines;
    logic [15:0] d;
    set_lines(16'h0008);
    check("R10 masked line no irq", {15'd0, irq}, 16'h0);
    bus_read(4'h0, d); check("R10 masked line no code", d, 16'h0000);
    set_lines(16'h8018);
    bus_read(4'h0, d); check("R10 only enabled line 4 coded", d, 16'h0014);
  endtask

  task automatic t_priority;
    logic [15:0] d;
    bus_write(4'h2, 2'b11, 16'hFFFF);
    bus_read(4'h2, d); check("R4 mask readback", d, 16'hFFFF);
    bus_read(4'h0, d); check("R3 lowest of 3,4,15", d, 16'h0010);
    set_lines(16'h8000);
    bus_read(4'h0, d); check("R3 line 15", d, 16'h0040);
    set_lines(16'h8001);
    bus_read(4'h0, d); check("R3 line 0", d, 16'h0004);
    set_lines(16'h0000);
    bus_read(4'h0, d); check("R3 none pending", d, 16'h0000);
    check("R1 R2 irq drops with lines", {15'd0, irq}, 16'h0);
  endtask

  task automatic t_mask_timing;
    set_lines(16'h0100);
    check("R2 irq with line 8", {15'd0, irq}, 16'h1);
    @(negedge clk);
    addr = 4'h2; be = 2'b11; wdata = 16'h0000; wr = 1'b1;
    @(negedge clk);  // write edge passed
    wr = 1'b0; be = 2'b00;
    check("R5 irq one edge after write still high", {15'd0, irq}, 16'h1);
    @(negedge clk);
    check("R5 irq low next edge", {15'd0, irq}, 16'h0);
    bus_write(4'h2, 2'b11, 16'h0100);
    @(negedge clk);
    check("R5 irq back on enable", {15'd0, irq}, 16'h1);
  endtask

  task automatic t_byte_writes;
    logic [15:0] d;
    bus_write(4'h2, 2'b11, 16'h1234);
    bus_write(4'h2, 2'b01, 16'h56AB);
    bus_read(4'h2, d); check("R7 low byte write", d, 16'h12AB);
    bus_write(4'h2, 2'b10, 16'hCD9E);
    bus_read(4'h2, d); check("R7 high byte write", d, 16'hCDAB);
  endtask

  task automatic t_src_write;
    logic [15:0] d;
    bus_write(4'h2, 2'b11, 16'h0000);
    set_lines(16'h0002);
    bus_write(4'h0, 2'b11, 16'hFFFF);
    @(negedge clk);
    bus_read(4'h2, d); check("R8 mask after source write", d, 16'h0000);
    check("R8 irq after source write", {15'd0, irq}, 16'h0);
  endtask

  task automatic t_unknown;
    logic [15:0] d;
    bus_write(4'h2, 2'b11, 16'hFFFF);
    bus_read(4'h4, d); check("R9 offset 4", d, 16'h0000);
    bus_read(4'h6, d); check("R9 offset 6", d, 16'h0000);
    bus_read(4'hE, d); check("R9 offset E", d, 16'h0000);
    bus_read(4'h0, d); check("R3 line 1", d, 16'h0008);
  endtask

  initial begin
    rst_n = 1'b0; lines = '0; addr = '0; rd = 1'b0; wr = 1'b0; be = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_single_line();
    t_masked_lines();
    t_priority();
    t_mask_timing();
    t_byte_writes();
    t_src_write();
    t_unknown();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule